// File: doc/BRIEF.md
# Address-Bus Configuration Register Loader

This block sits in the control path of a pseudo-static memory and holds its two configuration registers. One register sets how the memory behaves on its bus. The other sets how the memory array is refreshed. Software does not load these registers through the data pins. Instead, the host drives the register select input high and performs an asynchronous write. The value to store is taken from the 22-bit address bus. Address bit 19 chooses the register: 1 selects the bus register and 0 selects the refresh register. The value is committed on whichever of the three active-low strobes rises first: address-valid, chip-enable or write-enable.

The strobes, the select input, the standby indication and the address are brought into the block's clock domain through a register chain. Rising edges are found from the synchronized samples. The state machine has three states:
- `ST_IDLE` waits for a register write to start.
- `ST_ARMED` waits for the first strobe to rise, and loads the register at that edge.
- `ST_DRAIN` ignores every later edge until the access is over.

The transitions are:
- IDLE→ARMED: select high and all three strobes low.
- ARMED→DRAIN: any of the three strobes rises.
- DRAIN→IDLE: chip-enable, write-enable and output-enable are all high.

A write is accepted only while the memory reports standby. A write refused for that reason sets a sticky error flag. When an accepted write to the refresh register clears the deep power-down field, the block emits a one-cycle pulse to restart the refresh machinery.

Top module: `addrbus_cfg_loader`

## Requirements
- R1: After reset, `bus_cfg_o` equals BUS_DEFAULT (22'h089D1F), `rfr_cfg_o` equals RFR_DEFAULT (22'h000007), and `wr_err_o` and `dpd_exit_o` are 0.
- R2: A write access with `cfg_sel_i`=1, `standby_i`=1, and `adv_n_i`, `ce_n_i`, `we_n_i` all low, with `addr_i[19]`=1, loads all 22 address bits into `bus_cfg_o` and leaves `rfr_cfg_o` unchanged.
- R3: The same access with `addr_i[19]`=0 loads all 22 address bits into `rfr_cfg_o` and leaves `bus_cfg_o` unchanged.
- R4: The stored value is the address present while all three strobes were low, just before the first of them rises. This holds for each of the six rise orders. Later address changes and later strobe rises in the same access have no effect.
- R5: A write access with `cfg_sel_i`=0 changes neither register and does not set the error flag.
- R6: A read access (`we_n_i` high, `oe_n_i` low, `ce_n_i` low) with `cfg_sel_i`=1 changes neither register and does not set the error flag.
- R7: If `standby_i` is 0 when the first strobe rises, neither register changes and `wr_err_o` becomes 1. The flag stays 1 until reset. Later accepted writes still load normally.
- R8: Bit 4 of the refresh register is the deep power-down field (1 = powered down). `dpd_exit_o` is high for exactly one cycle when an accepted refresh write changes that bit from 1 to 0. It stays low on every other write.
- R9: Each register write access performs at most one load. No register changes except on the cycle that leaves `ST_ARMED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cfg_sel_i | input | 1 | High: write goes to a configuration register; low: to the array |
| adv_n_i | input | 1 | Address-valid strobe, active low |
| ce_n_i | input | 1 | Chip-enable strobe, active low |
| we_n_i | input | 1 | Write-enable strobe, active low |
| oe_n_i | input | 1 | Output-enable, active low; marks a read, and must be high to end an access |
| standby_i | input | 1 | Memory is in standby; register updates allowed |
| addr_i | input | 22 | Address bus carrying the register value |
| bus_cfg_o | output | 22 | Bus configuration register |
| rfr_cfg_o | output | 22 | Refresh configuration register |
| dpd_exit_o | output | 1 | One-cycle deep power-down exit pulse |
| wr_err_o | output | 1 | Sticky flag: a register write was refused outside standby |

## Verification
The assertions assume the following about the inputs:
- `addr_i`, `cfg_sel_i` and `standby_i` stay constant from the start of an access until the first strobe rises.
- Every strobe level lasts longer than the synchronizer chain.

Under these assumptions, the synchronized address and the synchronized strobes describe the same moment. The stimulus holds each level for at least four clocks. It disturbs the address only after the first rise, and it returns all strobes high between accesses. The sweep runs every rise order against both registers with alternating power-down values, then adds array writes, reads and refused writes.

// File: rtl/abcl_pkg.sv
package abcl_pkg;

    // Loader control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DRAIN = 2'd2
    } ctrl_state_e;

    // Number of strobes whose rising edge can commit a load
    localparam int N_EDGE_STROBES = 3;

endpackage

// File: rtl/abcl_sync.sv
module abcl_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/abcl_ctrl.sv
module abcl_ctrl
    import abcl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel_s,
    input  logic        adv_n_s,
    input  logic        ce_n_s,
    input  logic        we_n_s,
    input  logic        oe_n_s,
    input  logic        standby_s,
    output logic        load_o,
    output logic        reject_o,
    output ctrl_state_e state_o
);

    ctrl_state_e state_q, state_d;

    logic [N_EDGE_STROBES-1:0] strb_now;
    logic [N_EDGE_STROBES-1:0] strb_prev_q;
    logic [N_EDGE_STROBES-1:0] strb_rise;
    logic                      write_start;
    logic                      bus_quiet;
    logic                      first_edge;

    assign strb_now    = {adv_n_s, ce_n_s, we_n_s};
    assign strb_rise   = strb_now & ~strb_prev_q;
    assign write_start = cfg_sel_s & ~adv_n_s & ~ce_n_s & ~we_n_s;
    assign bus_quiet   = ce_n_s & we_n_s & oe_n_s;

    // Previous strobe samples for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_prev_q <= '1;
        else        strb_prev_q <= strb_now;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (write_start)  state_d = ST_ARMED;
            ST_ARMED: if (|strb_rise)   state_d = ST_DRAIN;
            ST_DRAIN: if (bus_quiet)    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        first_edge = (state_q == ST_ARMED) && (|strb_rise);
        load_o     = first_edge && standby_s;
        reject_o   = first_edge && !standby_s;
        state_o    = state_q;
    end

endmodule

// File: rtl/abcl_regs.sv
module abcl_regs #(
    parameter int                ADDR_W      = 22,
    parameter int                SEL_BIT     = 19,
    parameter int                DPD_BIT     = 4,
    parameter logic [ADDR_W-1:0] BUS_DEFAULT = '0,
    parameter logic [ADDR_W-1:0] RFR_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              load_i,
    input  logic              reject_i,
    output logic [ADDR_W-1:0] bus_cfg_o,
    output logic [ADDR_W-1:0] rfr_cfg_o,
    output logic              dpd_exit_o,
    output logic              wr_err_o
);

    logic [ADDR_W-1:0] shadow_q;
    logic [ADDR_W-1:0] bus_q;
    logic [ADDR_W-1:0] rfr_q;
    logic              exit_q;
    logic              err_q;
    logic              pick_bus;
    logic              clears_dpd;

    assign pick_bus   = shadow_q[SEL_BIT];
    assign clears_dpd = rfr_q[DPD_BIT] & ~shadow_q[DPD_BIT];

    // Address one cycle behind the strobes: the value seen while they were low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= addr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q  <= BUS_DEFAULT;
            rfr_q  <= RFR_DEFAULT;
            exit_q <= 1'b0;
        end else begin
            exit_q <= 1'b0;
            if (load_i) begin
                if (pick_bus) begin
                    bus_q <= shadow_q;
                end else begin
                    rfr_q  <= shadow_q;
                    exit_q <= clears_dpd;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (reject_i) err_q <= 1'b1;
    end

    assign bus_cfg_o  = bus_q;
    assign rfr_cfg_o  = rfr_q;
    assign dpd_exit_o = exit_q;
    assign wr_err_o   = err_q;

endmodule

// File: rtl/addrbus_cfg_loader.sv
module addrbus_cfg_loader
    import abcl_pkg::*;
#(
    parameter int                ADDR_W      = 22,
    parameter int                SEL_BIT     = 19,
    parameter int                DPD_BIT     = 4,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BUS_DEFAULT = 22'h089D1F,
    parameter logic [ADDR_W-1:0] RFR_DEFAULT = 22'h000007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel_i,
    input  logic              adv_n_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic              standby_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] bus_cfg_o,
    output logic [ADDR_W-1:0] rfr_cfg_o,
    output logic              dpd_exit_o,
    output logic              wr_err_o
);

    // Control vector order: {adv_n, ce_n, we_n, oe_n, cfg_sel, standby}
    localparam int               CTL_W    = 6;
    localparam logic [CTL_W-1:0] CTL_IDLE = 6'b111100;

    logic [CTL_W-1:0]  ctl_raw;
    logic [CTL_W-1:0]  ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic              load;
    logic              reject;
    ctrl_state_e       fsm_state;

    assign ctl_raw = {adv_n_i, ce_n_i, we_n_i, oe_n_i, cfg_sel_i, standby_i};

    abcl_sync #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctl_raw),
        .q_o   (ctl_s)
    );

    abcl_sync #(
        .WIDTH   (ADDR_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_addr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (addr_i),
        .q_o   (addr_s)
    );

    abcl_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sel_s (ctl_s[1]),
        .adv_n_s   (ctl_s[5]),
        .ce_n_s    (ctl_s[4]),
        .we_n_s    (ctl_s[3]),
        .oe_n_s    (ctl_s[2]),
        .standby_s (ctl_s[0]),
        .load_o    (load),
        .reject_o  (reject),
        .state_o   (fsm_state)
    );

    abcl_regs #(
        .ADDR_W      (ADDR_W),
        .SEL_BIT     (SEL_BIT),
        .DPD_BIT     (DPD_BIT),
        .BUS_DEFAULT (BUS_DEFAULT),
        .RFR_DEFAULT (RFR_DEFAULT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_s     (addr_s),
        .load_i     (load),
        .reject_i   (reject),
        .bus_cfg_o  (bus_cfg_o),
        .rfr_cfg_o  (rfr_cfg_o),
        .dpd_exit_o (dpd_exit_o),
        .wr_err_o   (wr_err_o)
    );

endmodule

// File: rtl/abcl_checker.sv
module abcl_checker
    import abcl_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DPD_BIT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_cfg,
    input logic [ADDR_W-1:0] rfr_cfg,
    input logic              dpd_exit,
    input logic              wr_err,
    input ctrl_state_e       state
);

    AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(bus_cfg) && !$stable(rfr_cfg))); // R2 R3

    AST_LOAD_LEAVES_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bus_cfg) || !$stable(rfr_cfg)) |-> ($past(state) == ST_ARMED && state == ST_DRAIN)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err); // R7

    AST_REFUSED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_err) |-> ($stable(bus_cfg) && $stable(rfr_cfg))); // R7

    AST_EXIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_exit |=> !dpd_exit); // R8

    AST_EXIT_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_exit |-> (!rfr_cfg[DPD_BIT] && $past(rfr_cfg[DPD_BIT]))); // R8

endmodule

bind addrbus_cfg_loader abcl_checker #(
    .ADDR_W  (ADDR_W),
    .DPD_BIT (DPD_BIT)
) u_abcl_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cfg  (bus_cfg_o),
    .rfr_cfg  (rfr_cfg_o),
    .dpd_exit (dpd_exit_o),
    .wr_err   (wr_err_o),
    .state    (fsm_state)
);

// File: tb/test_addrbus_cfg_loader.sv
module test_addrbus_cfg_loader;

    localparam int          CLK_PERIOD = 10;
    localparam logic [21:0] BUS_DEF    = 22'h089D1F;
    localparam logic [21:0] RFR_DEF    = 22'h000007;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        adv_n = 1'b1;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        standby = 1'b1;
    logic [21:0] addr = '0;
    logic [21:0] bus_cfg;
    logic [21:0] rfr_cfg;
    logic        dpd_exit;
    logic        wr_err;

    int n_chk = 0;
    int n_fail = 0;
    int exit_cnt = 0;
    int exit_long = 0;
    logic exit_prev = 1'b0;
    bit finished = 1'b0;

    logic [21:0] m_bus;
    logic [21:0] m_rfr;
    logic        m_err;
    int          m_exit;

    always #(CLK_PERIOD/2) clk = ~clk;

    addrbus_cfg_loader #(
        .BUS_DEFAULT (BUS_DEF),
        .RFR_DEFAULT (RFR_DEF)
    ) i_addrbus_cfg_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel_i  (cfg_sel),
        .adv_n_i    (adv_n),
        .ce_n_i     (ce_n),
        .we_n_i     (we_n),
        .oe_n_i     (oe_n),
        .standby_i  (standby),
        .addr_i     (addr),
        .bus_cfg_o  (bus_cfg),
        .rfr_cfg_o  (rfr_cfg),
        .dpd_exit_o (dpd_exit),
        .wr_err_o   (wr_err)
    );

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dpd_exit) exit_cnt++;
            if (dpd_exit && exit_prev) exit_long++;
            exit_prev = dpd_exit;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic raise(input int idx);
        case (idx)
            0:       adv_n = 1'b1;
            1:       ce_n  = 1'b1;
            default: we_n  = 1'b1;
        endcase
    endtask

    // One access; ord 0..5 selects the rise order of {adv, ce, we}
    task automatic access(input logic [21:0] a, input int ord, input logic cfg,
                          input logic stby, input logic is_wr);
        int first;
        int r0;
        int r1;
        int tmp;
        first = ord / 2;
        r0 = (first == 0) ? 1 : 0;
        r1 = (first == 2) ? 1 : 2;
        if (ord % 2 == 1) begin
            tmp = r0; r0 = r1; r1 = tmp;
        end
        @(negedge clk);
        addr = a; cfg_sel = cfg; standby = stby;
        adv_n = 1'b0; ce_n = 1'b0;
        if (is_wr) we_n = 1'b0; else oe_n = 1'b0;
        repeat (6) @(negedge clk);
        raise(first);
        repeat (4) @(negedge clk);
        addr = ~a;
        repeat (4) @(negedge clk);
        raise(r0);
        repeat (4) @(negedge clk);
        raise(r1);
        repeat (4) @(negedge clk);
        oe_n = 1'b1; cfg_sel = 1'b0; addr = '0; standby = 1'b1;
        repeat (8) @(negedge clk);
        // reference model
        if (cfg && is_wr) begin
            if (!stby) begin
                m_err = 1'b1;
            end else if (a[19]) begin
                m_bus = a;
            end else begin
                if (m_rfr[4] && !a[4]) m_exit++;
                m_rfr = a;
            end
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " bus"}, 32'(bus_cfg), 32'(m_bus));
        chk({req, " rfr"}, 32'(rfr_cfg), 32'(m_rfr));
        chk({req, " err"}, 32'(wr_err), 32'(m_err));
        chk({req, " R8 exit count"}, 32'(exit_cnt), 32'(m_exit));
    endtask

    initial begin
        m_bus = BUS_DEF; m_rfr = RFR_DEF; m_err = 1'b0; m_exit = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1
        chk("R1 bus default", 32'(bus_cfg), 32'(BUS_DEF));
        chk("R1 rfr default", 32'(rfr_cfg), 32'(RFR_DEF));
        chk("R1 err", 32'(wr_err), 32'd0);
        chk("R1 exit", 32'(dpd_exit), 32'd0);

        // R2 R3 R4 R8: every rise order, both registers, power-down set then cleared
        for (int rs = 0; rs < 2; rs++) begin
            for (int ord = 0; ord < 6; ord++) begin
                for (int pat = 0; pat < 2; pat++) begin
                    logic [21:0] a;
                    a = 22'((ord * 37 + pat * 1001 + rs * 5 + 3) * 499) ^ 22'h2A5C3;
                    a[19] = (rs == 1);
                    a[4]  = (pat == 0);
                    access(a, ord, 1'b1, 1'b1, 1'b1);
                    check_all(rs == 1 ? "R2 R4" : "R3 R4");
                end
            end
        end

        // R5: array write with select low
        access(22'h3FFFFF, 0, 1'b0, 1'b1, 1'b1);
        check_all("R5 bus-sel");
        access(22'h000000, 3, 1'b0, 1'b1, 1'b1);
        check_all("R5 rfr-sel");

        // R6: read with select high
        access(22'h0BEEF0, 1, 1'b1, 1'b1, 1'b0);
        check_all("R6 read bus-sel");
        access(22'h012340, 4, 1'b1, 1'b1, 1'b0);
        check_all("R6 read rfr-sel");

        // R8: set power-down, then a refused clear must not pulse
        access(22'h000013, 2, 1'b1, 1'b1, 1'b1);
        check_all("R8 set");
        // R7: refused write outside standby
        access(22'h000002, 5, 1'b1, 1'b0, 1'b1);
        check_all("R7 refused rfr");
        access(22'h0C0C0C, 1, 1'b1, 1'b0, 1'b1);
        check_all("R7 refused bus");
        // R7 sticky, later writes still load; R8 clear now pulses
        access(22'h000021, 0, 1'b1, 1'b1, 1'b1);
        check_all("R7 R8 accepted after error");
        access(22'h0ABCDE, 5, 1'b1, 1'b1, 1'b1);
        check_all("R7 sticky bus");
        // R8 clear while already clear: no pulse
        access(22'h000000, 2, 1'b1, 1'b1, 1'b1);
        check_all("R8 no pulse");
        chk("R8 pulse width", 32'(exit_long), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule